// File: doc/BRIEF.md
# Sustained Pulse Activity Latch Timer

This block watches an asynchronous pulse stream and decides whether the stream has stayed active without a break for a long qualifying interval. Each rising edge on the input re-arms an inactivity window that lasts a set number of slow ticks. While that window is alive, a binary duration counter advances once per tick. If the window runs out, the counter is forced to zero and stays there until a new edge arrives.

The slow tick comes from a divider on the system clock. When the counter's top stage first sets, the output latches high to enable an external load. While latched, the counter is frozen and any reset from window expiry is ignored. Only the manual clear input, or the synchronous reset, brings the output low again. The manual clear leaves the window untouched, so counting restarts at once if pulses are still arriving. With the default parameters and a 100 MHz clock, the tick is about 0.44 s, the window about one minute and the qualifying interval about one hour.

Top module: `pulse_activity_latch`

## Requirements
- R1: Each rising edge of `pulse_i`, taken after a two-flop synchronizer, reloads the inactivity window to WIN_TICKS ticks. Edges spaced closer than the window keep the block active without a break.
- R2: When the window expires, the duration counter clears to zero and stays at zero until a new edge re-arms the window. A later run must then count the full interval again.
- R3: A tick is produced once every TICK_DIV system clocks. While the window is active and the output is low, the counter advances by one on each tick.
- R4: `load_on_o` is a registered output equal to the counter's top stage. It first rises after 2^(DUR_STAGES-1) ticks of continuous activity.
- R5: Once `load_on_o` is high, it stays high when pulses stop, and window expiry does not reset the counter.
- R6: `clear_i` is active-high and sampled on the clock. On the next edge it drives `load_on_o` low and the counter to zero.
- R7: `clear_i` does not change the inactivity window. If the window is still active when the clear is released, counting resumes at once from zero.
- R8: An input held high re-arms the window only on its single rising edge. A stuck-high input therefore never runs out the interval.
- R9: While `load_on_o` is high, the counter holds its terminal value. It cannot wrap, so `load_on_o` stays high even if pulses continue.
- R10: `rst_i` is synchronous and active-high. It marks the window inactive, zeroes the counter and drives `load_on_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Asynchronous activity pulse input |
| clear_i | input | 1 | Manual clear of the latched output |
| load_on_o | output | 1 | Latched load enable |

## Verification
The stream is driven in several shapes, and each shape separates a different fault:
- Pulses spaced wider than the window show that expiry really empties the counter.
- A dense train checks both sides of the qualifying instant, which catches an off-by-one or a wrong stage choice.
- A dense train that continues well past the latch exposes a counter that wraps instead of freezing.
- Silence after the latch exposes an expiry reset leaking through.
- A held-high level tells edge qualification apart from level sensing.
- A short burst, a long gap and then a new train show that a broken run must start over from zero.
- A clear issued in the middle of a live train shows that the window survives the clear and counting resumes from zero.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Counter width that can hold values 0..n-1, never below one bit.
  function automatic int unsigned span_w(input int unsigned n);
    int unsigned w;
    w = (n <= 2) ? 1 : $clog2(n);
    return w;
  endfunction
endpackage

// File: rtl/pal_edge_qual.sv
module pal_edge_qual (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= '0;
    else       sync_q <= {sync_q[1:0], raw_i};
  end

  // Stage 1 is the synchronized level; stage 2 is its previous value.
  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/pal_tick_gen.sv
module pal_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int unsigned DW = pal_pkg::span_w(TICK_DIV);
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == LAST);
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pal_window.sv
module pal_window #(
  parameter int unsigned WIN_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rearm_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int unsigned WW = pal_pkg::span_w(WIN_TICKS + 1);
  localparam logic [WW-1:0] FULL = WW'(WIN_TICKS);

  logic [WW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                       left_q <= '0;
    else if (rearm_i)                left_q <= FULL;
    else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/pal_duration.sv
module pal_duration #(
  parameter int unsigned STAGES = 14
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clear_i,
  input  logic              active_i,
  input  logic              tick_i,
  output logic [STAGES-1:0] count_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] cnt_q;
  logic              held;

  assign held = cnt_q[TOP];

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) cnt_q <= '0;
    else if (held)        cnt_q <= cnt_q;        // frozen at terminal state
    else if (!active_i)   cnt_q <= '0;           // window expired
    else if (tick_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pulse_activity_latch.sv
module pulse_activity_latch #(
  parameter int unsigned TICK_DIV   = 44_000_000,
  parameter int unsigned WIN_TICKS  = 136,
  parameter int unsigned DUR_STAGES = 14
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pulse_i,
  input  logic clear_i,
  output logic load_on_o
);
  logic                  pulse_edge;
  logic                  tick;
  logic                  win_active;
  logic [DUR_STAGES-1:0] cnt_q;

  pal_edge_qual u_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .raw_i (pulse_i),
    .rise_o(pulse_edge)
  );

  pal_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_o(tick)
  );

  pal_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rearm_i (pulse_edge),
    .tick_i  (tick),
    .active_o(win_active)
  );

  pal_duration #(.STAGES(DUR_STAGES)) u_dur (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (clear_i),
    .active_i(win_active),
    .tick_i  (tick),
    .count_o (cnt_q)
  );

  // The top stage is a flop, so the output is registered.
  assign load_on_o = cnt_q[DUR_STAGES-1];
endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
  parameter int unsigned CW = 14
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          clear_i,
  input logic          edge_i,
  input logic          active_i,
  input logic [CW-1:0] cnt_i,
  input logic          load_on_i
);
  AST_EDGE_ARMS: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_i |=> active_i); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!active_i && !load_on_i) |=> (cnt_i == '0)); // R2

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_i && !load_on_i && !clear_i) |=>
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1)); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_on_i && !clear_i) |=> load_on_i); // R5

  AST_CLEAR_WIPES: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> (!load_on_i && cnt_i == '0)); // R6

  AST_FROZEN_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_on_i && !clear_i) |=> $stable(cnt_i)); // R9
endmodule

bind pulse_activity_latch pal_checker #(.CW(DUR_STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .clear_i  (clear_i),
  .edge_i   (pulse_edge),
  .active_i (win_active),
  .cnt_i    (cnt_q),
  .load_on_i(load_on_o)
);

// File: tb/pulse_activity_latch_tb_top.sv
module pulse_activity_latch_tb_top;
  // Small values: tick every 4 clocks, 3-tick window, 16 ticks to latch.
  localparam int unsigned TD = 4;
  localparam int unsigned WT = 3;
  localparam int unsigned DS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic clr = 1'b0;
  logic out;

  always #5 clk = ~clk;

  pulse_activity_latch #(.TICK_DIV(TD), .WIN_TICKS(WT), .DUR_STAGES(DS)) dut_i (
    .clk_i    (clk),
    .rst_i    (rst),
    .pulse_i  (pin),
    .clear_i  (clr),
    .load_on_o(out)
  );

  typedef struct {
    int    due;
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations when their cycle comes due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out !== e.val) begin
        errors++;
        $display("FAIL %s cycle %0d: load_on_o=%b expected %b", e.tag, cyc, out, e.val);
      end
    end
  end

  task automatic expect_at(input int delta, input bit v, input string tag);
    exp_t e;
    e.due = cyc + delta;
    e.val = v;
    e.tag = tag;
    // keep the queue ordered by due cycle
    begin
      int k = 0;
      while (k < q.size() && q[k].due <= e.due) k++;
      q.insert(k, e);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One pulse: high 2 clocks, low (period-2) clocks.
  task automatic pulses(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1;
      wait_clk(2);
      pin = 1'b0;
      wait_clk(period - 2);
    end
  endtask

  initial begin
    wait_clk(3);
    expect_at(1, 1'b0, "R10 reset state");
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);

    // R1/R2: pulses spaced 24 clocks, wider than the window: never latches
    expect_at(470, 1'b0, "R2 wide gaps");
    pulses(20, 24);

    // R3/R4: dense train (8 clocks) latches after 16 ticks, not before
    expect_at(58, 1'b0, "R4 not yet");
    expect_at(80, 1'b1, "R4 latched R3");
    pulses(10, 8);

    // R9: keep pulsing long enough for a wrap; must stay high
    expect_at(130, 1'b1, "R9 no wrap");
    pulses(17, 8);

    // R5: pulses stop; expiry must not reset the latch
    expect_at(250, 1'b1, "R5 hold idle");
    wait_clk(260);

    // R6: manual clear
    clr = 1'b1;
    expect_at(1, 1'b0, "R6 clear");
    wait_clk(1);
    clr = 1'b0;
    expect_at(150, 1'b0, "R6 stays low");
    wait_clk(160);

    // R8: stuck-high input
    pin = 1'b1;
    expect_at(390, 1'b0, "R8 stuck high");
    wait_clk(400);
    pin = 1'b0;
    wait_clk(30);

    // R2: partial run, break, restart must count full interval
    pulses(5, 8);
    wait_clk(40);
    expect_at(58, 1'b0, "R2 restart from zero");
    expect_at(80, 1'b1, "R4 relatch");
    pulses(10, 8);

    // R7: clear during live train; counting resumes at once
    for (int i = 0; i < 10; i++) begin
      pin = 1'b1;
      if (i == 0) begin
        clr = 1'b1;
        expect_at(1, 1'b0, "R6 clear live");
        expect_at(58, 1'b0, "R7 resume early");
        expect_at(80, 1'b1, "R7 resume latch");
      end
      wait_clk(1);
      clr = 1'b0;
      wait_clk(1);
      pin = 1'b0;
      wait_clk(6);
    end

    // R10: reset while latched
    rst = 1'b1;
    expect_at(1, 1'b0, "R10 reset latched");
    wait_clk(2);
    rst = 1'b0;
    wait_clk(10);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule